// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Status

This block is the receive side of an asynchronous serial port. A baud generator elsewhere supplies a strobe that is sixteen times the bit rate. On each strobe the block samples a synchronised copy of the incoming line and builds characters of 5 to 9 data bits, least significant bit first. It can check an optional even or odd parity bit and checks one stop bit. Each finished character goes into a two-deep queue together with its own parity and framing flags. Because the flags travel with the character, software always sees the error for the exact character it reads.

Software reaches the block through a small word-addressed register port. A read of the receive word returns the oldest entry and removes it. A status register shows whether the receiver is on, whether data is waiting and whether the queue is full. Two interrupt flags are kept: one for "a character was stored" and one for "a character was lost because the queue was full". Software can set, clear and enable these flags. The interrupt output is high while any enabled flag is set.

Register map (word address on `bus_addr`): 0 command (write), 1 status (read), 2 receive word (read, removes the entry), 3 flags (read), 4 flag set (write), 5 flag clear (write), 6 flag enable (read/write). Frame configuration: `cfg_par` 00 or 01 means no parity, 10 means even, 11 means odd. `cfg_nbits` below 5 is treated as 5, and above 9 as 9.

Top module: `uart_rx_ext`

## Requirements
- R1: After reset the receiver is disabled. Status, flags and flag-enable all read 0, and `rx_valid` and `rx_irq` are low.
- R2: A character's data bits arrive least significant bit first. The character's width comes from `cfg_nbits` and can be 5 to 9 bits. The data appears right-aligned in bits 8:0 of the receive word, and the unused upper data bits read 0.
- R3: When parity is on, a wrong parity bit sets bit 14 of the receive word for that character. Even parity means the data bits plus the parity bit hold an even number of ones; odd parity means they hold an odd number. With parity off, no parity bit is expected and bit 14 stays 0.
- R4: Only the first stop bit is checked, even when `cfg_stop2` asks for two stop bits. A low first stop bit sets bit 15 of the receive word.
- R5: A break (the line held low through the whole frame) is stored as one entry with bit 15 set and all data bits 0. No further frame starts until the line has been seen high again.
- R6: Bits 13:9 of the receive word always read 0.
- R7: Status bit 1 and `rx_valid` stay high while the queue holds any entry. Repeated reads of the receive word return the entries oldest first. A read while the queue is empty returns 0 and changes nothing.
- R8: The queue holds two entries. A character that completes while the queue is full is thrown away, the stored entries are kept, and flag bit 4 (overflow) is set and stays set. Status bit 2 shows that the queue is full.
- R9: Flag bit 2 is set each time a character is stored. Writing a 1 to a bit of the flag-set register sets that flag, and writing a 1 to a bit of the flag-clear register clears it. Only bits 2 and 4 exist, and other bits read 0.
- R10: `rx_irq` is high exactly when a flag is set whose matching bit is also set in the enable register (address 6).
- R11: Command bit 0 turns the receiver on and command bit 1 turns it off; when both are written together, turning off wins. A disabled receiver ignores the line. Turning it off in the middle of a frame drops that frame but keeps the entries already stored. Status bit 0 shows whether the receiver is on.
- R12: A start bit counts only if the line is still low at the middle of the bit, 8 strobes after the falling edge was seen. A shorter low pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling strobe, one pulse per 1/16 bit |
| rxd | input | 1 | Serial line, idle high |
| cfg_nbits | input | 4 | Data bits per character (5..9) |
| cfg_par | input | 2 | Parity mode: bit 1 turns parity on, bit 0 selects odd |
| cfg_stop2 | input | 1 | Two stop bits configured (the second is not checked) |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (removes the entry when reading the receive word) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| rx_valid | output | 1 | Receive queue not empty |
| rx_irq | output | 1 | Interrupt: any enabled flag set |

## Verification
The assertions assume that the frame configuration stays fixed while a character is on the line, and that the oversampling strobe is a pulse one clock wide. They also assume that reads and writes on the register port are single-cycle strobes, with no read and write in the same cycle. The bench generates the strobe with a fixed divider and changes the configuration only while the line is idle. It drives the register port in one-cycle pulses on the falling clock edge and issues one access at a time. The one exception is the abort test: there the disable command is written while a frame is on the line, to show that the frame is dropped.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  localparam int ADDR_CMD  = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_WORD = 2;
  localparam int ADDR_FLAG = 3;
  localparam int ADDR_FSET = 4;
  localparam int ADDR_FCLR = 5;
  localparam int ADDR_FEN  = 6;

  localparam int FLG_RXV  = 2;
  localparam int FLG_OVF  = 4;
  localparam int WORD_PERR = 14;
  localparam int WORD_FERR = 15;

  // Returns 1 when the received parity bit does not match the mode.
  function automatic logic parity_bad(input logic [15:0] data, input logic pbit,
                                      input logic odd);
    return (^data) ^ pbit ^ odd;
  endfunction

  // The shift register fills from its top bit, so a short character
  // ends up left-aligned; move it down to bit 0.
  function automatic logic [15:0] align_lsb(input logic [15:0] sh, input int unsigned nb,
                                            input int unsigned dw);
    return sh >> (dw - nb);
  endfunction

  function automatic int unsigned clamp_bits(input logic [3:0] cfg, input int unsigned dw);
    if (int'(cfg) < 5) return 5;
    if (int'(cfg) > int'(dw)) return dw;
    return int'(cfg);
  endfunction

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OS = 16,
  parameter int unsigned DW = 9,
  localparam int unsigned CW = $clog2(OS),
  localparam int unsigned BW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          line_i,
  input  logic [BW-1:0] nbits_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  output logic          push_o,
  output logic [DW+1:0] word_o
);

  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] idx;
  logic [DW-1:0] sh;
  logic          prev;
  logic          perr;
  logic [DW-1:0] aligned;

  // Named internal events
  logic start_seen, half_pt, bit_pt, last_bit;
  assign start_seen = tick_i && (st == RX_IDLE) && prev && !line_i;
  assign half_pt    = tick_i && (cnt == CW'(OS / 2 - 1));
  assign bit_pt     = tick_i && (cnt == CW'(OS - 1));
  assign last_bit   = (idx == nbits_i - BW'(1));
  assign aligned    = DW'(align_lsb(16'(sh), int'(nbits_i), DW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
      prev   <= 1'b0;
      perr   <= 1'b0;
      push_o <= 1'b0;
      word_o <= '0;
    end else begin
      push_o <= 1'b0;
      if (!en_i) begin
        st   <= RX_IDLE;
        prev <= 1'b0;
      end else if (tick_i) begin
        prev <= line_i;
        unique case (st)
          RX_IDLE: begin
            if (start_seen) begin
              st  <= RX_START;
              cnt <= '0;
            end
          end
          RX_START: begin
            cnt <= cnt + CW'(1);
            if (half_pt) begin
              if (!line_i) begin
                st   <= RX_DATA;
                cnt  <= '0;
                idx  <= '0;
                sh   <= '0;
                perr <= 1'b0;
              end else begin
                st <= RX_IDLE;
              end
            end
          end
          RX_DATA: begin
            cnt <= cnt + CW'(1);
            if (bit_pt) begin
              cnt <= '0;
              sh  <= {line_i, sh[DW-1:1]};
              idx <= idx + BW'(1);
              if (last_bit) st <= par_en_i ? RX_PAR : RX_STOP;
            end
          end
          RX_PAR: begin
            cnt <= cnt + CW'(1);
            if (bit_pt) begin
              cnt  <= '0;
              perr <= parity_bad(16'(aligned), line_i, par_odd_i);
              st   <= RX_STOP;
            end
          end
          RX_STOP: begin
            cnt <= cnt + CW'(1);
            if (bit_pt) begin
              cnt    <= '0;
              push_o <= 1'b1;
              word_o <= {!line_i, perr, aligned};
              st     <= RX_IDLE;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R11: disabling the receiver aborts any frame in progress
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st == RX_IDLE));

  // R4: a character is delivered only from the stop-bit check
  p_push_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> $past(st == RX_STOP));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned W     = 11,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned NW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         valid_o,
  output logic         full_o,
  output logic         drop_o,
  output logic         stored_o
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] cnt;
  logic          do_pop, do_push;

  assign valid_o  = (cnt != '0);
  assign full_o   = (cnt == NW'(DEPTH));
  assign do_pop   = pop_i && valid_o;
  assign do_push  = push_i && (!full_o || do_pop);
  assign drop_o   = push_i && full_o && !do_pop;
  assign stored_o = do_push;
  assign head_o   = mem[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + NW'(1);
        2'b01:   cnt <= cnt - NW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: a discarded character leaves the stored entries untouched
  p_keep_on_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |=> $stable(cnt) && full_o);

  // R7: taking the last entry empties the queue
  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push && cnt == NW'(1)) |=> !valid_o);

endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
  import uart_rx_pkg::*;
#(
  parameter int unsigned FW = 16,
  localparam logic [FW-1:0] MASK = FW'((1 << FLG_RXV) | (1 << FLG_OVF))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxv_i,
  input  logic          ovf_i,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic          ien_we,
  input  logic [FW-1:0] wdata,
  output logic [FW-1:0] flags_o,
  output logic [FW-1:0] ien_o,
  output logic          irq_o
);

  logic [FW-1:0] hw_set, sw_set, sw_clr;

  assign hw_set = (FW'(rxv_i) << FLG_RXV) | (FW'(ovf_i) << FLG_OVF);
  assign sw_set = set_we ? wdata : '0;
  assign sw_clr = clr_we ? wdata : '0;
  assign irq_o  = |(flags_o & ien_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_o <= '0;
      ien_o   <= '0;
    end else begin
      flags_o <= ((flags_o & ~sw_clr) | sw_set | hw_set) & MASK;
      if (ien_we) ien_o <= wdata & MASK;
    end
  end

  // R8: an overflow event leaves the overflow flag set
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> flags_o[FLG_OVF]);

  // R9: writing a one to the clear register drops the data-valid flag
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wdata[FLG_RXV] && !rxv_i && !(set_we && wdata[FLG_RXV])) |=> !flags_o[FLG_RXV]);

  // R10: the interrupt only rises after a flag or enable change
  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(rxv_i || ovf_i || set_we || ien_we));

endmodule

// File: rtl/uart_rx_ext.sv
module uart_rx_ext
  import uart_rx_pkg::*;
#(
  parameter int unsigned DW    = 9,
  parameter int unsigned DEPTH = 2,
  parameter int unsigned OS    = 16,
  parameter int unsigned SYNC  = 2,
  parameter int unsigned AW    = 4,
  parameter int unsigned BUSW  = 16,
  localparam int unsigned BW = $clog2(DW + 1),
  localparam int unsigned EW = DW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            os_tick,
  input  logic            rxd,
  input  logic [3:0]      cfg_nbits,
  input  logic [1:0]      cfg_par,
  input  logic            cfg_stop2,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [BUSW-1:0] bus_wdata,
  output logic [BUSW-1:0] bus_rdata,
  output logic            rx_valid,
  output logic            rx_irq
);

  // Line synchroniser
  logic [SYNC-1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], rxd};
  end

  // Decoded accesses
  logic cmd_wr, word_rd, set_we, clr_we, ien_we;
  assign cmd_wr  = bus_wr && (bus_addr == AW'(ADDR_CMD));
  assign word_rd = bus_rd && (bus_addr == AW'(ADDR_WORD));
  assign set_we  = bus_wr && (bus_addr == AW'(ADDR_FSET));
  assign clr_we  = bus_wr && (bus_addr == AW'(ADDR_FCLR));
  assign ien_we  = bus_wr && (bus_addr == AW'(ADDR_FEN));

  logic rx_en;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_en <= 1'b0;
    else if (cmd_wr) begin
      if (bus_wdata[1])      rx_en <= 1'b0;
      else if (bus_wdata[0]) rx_en <= 1'b1;
    end
  end

  // Frame engine
  logic [BW-1:0] nbits;
  logic          push;
  logic [EW-1:0] word;
  assign nbits = BW'(clamp_bits(cfg_nbits, DW));

  uart_rx_frame #(.OS(OS), .DW(DW)) frame_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (rx_en),
    .tick_i   (os_tick),
    .line_i   (sync_q[SYNC-1]),
    .nbits_i  (nbits),
    .par_en_i (cfg_par[1]),
    .par_odd_i(cfg_par[0]),
    .push_o   (push),
    .word_o   (word)
  );

  // Receive queue
  logic [EW-1:0] head;
  logic          q_valid, q_full, q_drop, q_stored;

  uart_rx_fifo #(.W(EW), .DEPTH(DEPTH)) fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .din_i   (word),
    .pop_i   (word_rd),
    .head_o  (head),
    .valid_o (q_valid),
    .full_o  (q_full),
    .drop_o  (q_drop),
    .stored_o(q_stored)
  );

  // Interrupt flags
  logic [BUSW-1:0] flags, ien;

  uart_rx_irq #(.FW(BUSW)) irq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rxv_i  (q_stored),
    .ovf_i  (q_drop),
    .set_we (set_we),
    .clr_we (clr_we),
    .ien_we (ien_we),
    .wdata  (bus_wdata),
    .flags_o(flags),
    .ien_o  (ien),
    .irq_o  (rx_irq)
  );

  assign rx_valid = q_valid;

  // Extended receive word: data low, error flags in the top bits
  logic [BUSW-1:0] rx_word;
  always_comb begin
    rx_word            = '0;
    rx_word[DW-1:0]    = head[DW-1:0];
    rx_word[WORD_PERR] = head[DW];
    rx_word[WORD_FERR] = head[DW+1];
    if (!q_valid) rx_word = '0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADDR_STAT))      bus_rdata = BUSW'({q_full, q_valid, rx_en});
    else if (bus_addr == AW'(ADDR_WORD)) bus_rdata = rx_word;
    else if (bus_addr == AW'(ADDR_FLAG)) bus_rdata = flags;
    else if (bus_addr == AW'(ADDR_FEN))  bus_rdata = ien;
  end

  // R11: disable wins over enable in one command write
  p_disable_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[0] && bus_wdata[1]) |=> !rx_en);

  // R7: the valid output follows a store into an empty queue
  p_valid_after_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_stored && !word_rd) |=> rx_valid);

endmodule

// File: tb/uart_rx_ext_tb.sv
module uart_rx_ext_tb_top;

  localparam int DIV   = 4;
  localparam int BITC  = 16 * DIV;
  localparam int DEPTH = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        os_tick;
  logic        rxd;
  logic [3:0]  cfg_nbits;
  logic [1:0]  cfg_par;
  logic        cfg_stop2;
  logic [3:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        rx_valid, rx_irq;

  always #5 clk = ~clk;

  uart_rx_ext dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_nbits(cfg_nbits), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_irq(rx_irq)
  );

  // Reference model
  int mq[$];
  int mflags = 0;
  int mien   = 0;
  bit men    = 0;
  bit cmp_en = 0;
  int vecs   = 0;
  int errs   = 0;
  bit done   = 0;

  task automatic chk(input string req, input int got, input int exp);
    vecs++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // Per-clock comparison of the outputs against the model
  always @(posedge clk) begin
    #3;
    if (cmp_en && !done) begin
      vecs++;
      if (rx_valid !== (mq.size() != 0)) begin
        errs++;
        $display("FAIL R7 rx_valid: got %0b expected %0b", rx_valid, mq.size() != 0);
      end
      vecs++;
      if (rx_irq !== ((mflags & mien) != 0)) begin
        errs++;
        $display("FAIL R10 rx_irq: got %0b expected %0b", rx_irq, (mflags & mien) != 0);
      end
    end
  end

  initial begin
    os_tick = 1'b0;
    forever begin
      repeat (DIV - 1) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 4'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
    case (a)
      0: begin if (d & 2) men = 0; else if (d & 1) men = 1; end
      4: mflags = (mflags | d) & 'h14;
      5: mflags = mflags & ~d;
      6: mien = d & 'h14;
      default: ;
    endcase
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_addr = 4'(a); bus_rd = 1'b1;
    #1 v = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic int exp_status();
    return ((mq.size() == DEPTH) ? 4 : 0) | ((mq.size() != 0) ? 2 : 0) | (men ? 1 : 0);
  endfunction

  task automatic read_word(input string req, output int v);
    int e;
    @(negedge clk);
    bus_addr = 4'd2; bus_rd = 1'b1;
    #1 v = int'(bus_rdata);
    e = (mq.size() != 0) ? mq.pop_front() : 0;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, v, e);
  endtask

  task automatic drive_bit(input bit b);
    rxd = b;
    repeat (BITC) @(negedge clk);
  endtask

  // pmode: 0 none, 1 even, 2 odd
  task automatic send(input int data, input int nb, input int pmode, input bit stop1,
                      input bit badp, input bit brk);
    bit p;
    cmp_en = 0;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(brk ? 1'b0 : data[i]);
    if (pmode != 0) begin
      p = 1'b0;
      for (int i = 0; i < nb; i++) p ^= data[i];
      if (pmode == 2) p = ~p;
      drive_bit(brk ? 1'b0 : (p ^ badp));
    end
    drive_bit(brk ? 1'b0 : stop1);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  // Model update after a frame; store says whether a character completed
  task automatic commit(input bit store, input int word);
    if (store && men) begin
      if (mq.size() == DEPTH) mflags |= 'h10;
      else begin
        mq.push_back(word);
        mflags |= 'h04;
      end
    end
    cmp_en = 1;
  endtask

  task automatic setcfg(input int nb, input int par, input bit s2);
    @(negedge clk);
    cfg_nbits = 4'(nb); cfg_par = 2'(par); cfg_stop2 = s2;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int v;
    rst_n = 1'b0; rxd = 1'b1;
    cfg_nbits = 4'd8; cfg_par = 2'b00; cfg_stop2 = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_en = 1;

    // R1 reset state
    rd(1, v); chk("R1 status", v, 0);
    rd(3, v); chk("R1 flags", v, 0);
    rd(6, v); chk("R1 enable", v, 0);
    chk("R1 rx_valid", int'(rx_valid), 0);
    chk("R1 rx_irq", int'(rx_irq), 0);

    // R11 line ignored while disabled
    send('h55, 8, 0, 1, 0, 0); commit(1, 'h55);
    rd(1, v); chk("R11 disabled status", v, 0);

    wr(0, 1);
    rd(1, v); chk("R11 enabled status", v, exp_status());
    wr(6, 'h14);
    rd(6, v); chk("R10 enable readback", v, 'h14);

    // R2 eight bits, no parity
    send('hA5, 8, 0, 1, 0, 0); commit(1, 'h0A5);
    rd(3, v); chk("R9 rx flag set", v, mflags);
    chk("R10 irq after store", int'(rx_irq), 1);
    read_word("R2 8-bit word", v);
    wr(5, 'h04);
    rd(3, v); chk("R9 flag cleared", v, 0);

    // R2 five and nine bits
    setcfg(5, 0, 0);
    send('h13, 5, 0, 1, 0, 0); commit(1, 'h13);
    read_word("R2 5-bit word", v);
    setcfg(9, 0, 0);
    send('h1C3, 9, 0, 1, 0, 0); commit(1, 'h1C3);
    read_word("R2 9-bit word", v);

    // R3 parity
    setcfg(8, 2, 0);
    send('h3C, 8, 1, 1, 0, 0); commit(1, 'h003C);
    read_word("R3 even good", v);
    send('h3C, 8, 1, 1, 1, 0); commit(1, 'h403C);
    read_word("R3 even bad", v);
    setcfg(8, 3, 0);
    send('h07, 8, 2, 1, 0, 0); commit(1, 'h0007);
    read_word("R3 odd good", v);
    send('h07, 8, 2, 1, 1, 0); commit(1, 'h4007);
    read_word("R3 odd bad", v);

    // R4 first stop bit checked with two stop bits configured
    setcfg(8, 0, 1);
    send('h5A, 8, 0, 0, 0, 0); commit(1, 'h805A);
    read_word("R4 first stop low", v);
    send('h5A, 8, 0, 1, 0, 0); commit(1, 'h005A);
    read_word("R4 stop good", v);

    // R6 reserved bits with all data ones and both errors
    setcfg(9, 2, 0);
    send('h1FF, 9, 1, 0, 1, 0); commit(1, 'hC1FF);
    read_word("R6 full word", v);
    chk("R6 bits 13:9 zero", (v >> 9) & 'h1F, 0);

    // R5 break
    setcfg(8, 0, 0);
    send(0, 8, 0, 0, 0, 1); commit(1, 'h8000);
    repeat (3 * BITC) @(negedge clk);
    rd(1, v); chk("R5 one entry after break", v, exp_status());
    read_word("R5 break word", v);

    // R8 overflow, R7 ordering and drain
    wr(5, 'h14);
    send('h11, 8, 0, 1, 0, 0); commit(1, 'h11);
    send('h22, 8, 0, 1, 0, 0); commit(1, 'h22);
    rd(1, v); chk("R8 full status", v, exp_status());
    send('h33, 8, 0, 1, 0, 0); commit(1, 'h33);
    rd(3, v); chk("R8 overflow flag", v, mflags);
    read_word("R7 first entry", v);
    rd(1, v); chk("R7 still valid", v, exp_status());
    read_word("R8 second entry kept", v);
    read_word("R7 empty read", v);
    rd(3, v); chk("R8 overflow sticky", v, mflags);

    // R9 set and clear registers
    wr(5, 'hFFFF);
    rd(3, v); chk("R9 clear all", v, 0);
    wr(4, 'hFFFF);
    rd(3, v); chk("R9 set mask", v, 'h14);
    wr(6, 'h00);
    chk("R10 irq masked", int'(rx_irq), 0);
    wr(5, 'h14);
    wr(6, 'h14);

    // R12 short low pulse
    cmp_en = 0;
    rxd = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    commit(0, 0);
    rd(1, v); chk("R12 glitch rejected", v, exp_status());

    // R11 abort mid-frame keeps stored entry
    send('h44, 8, 0, 1, 0, 0); commit(1, 'h44);
    fork
      send('h66, 8, 0, 1, 0, 0);
      begin
        repeat (4 * BITC) @(negedge clk);
        wr(0, 3);
      end
    join
    commit(0, 0);
    wr(0, 1);
    repeat (2 * BITC) @(negedge clk);
    rd(1, v); chk("R11 abort keeps entry", v, exp_status());
    read_word("R11 stored entry intact", v);
    send('h99, 8, 0, 1, 0, 0); commit(1, 'h99);
    read_word("R11 recovery frame", v);

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule